// File: doc/BRIEF.md
# GPIO Bank Data and Direction Port

This block is the data path of one bank of general-purpose pins, reached through a 32-bit register window addressed by byte offset. It holds a direction register and an output latch per pin, and drives a pad output value and a pad output enable for every pin. Each pin's input level is resynchronised into the clock domain and then captured into a data-in register that software can read.

Software changes single pins without a read-modify-write by writing to one of two alias offsets. A write to the set alias turns on every latch bit written as 1. A write to the clear alias turns off every latch bit written as 1. In both cases the latch bits written as 0 keep their value. A direct write to the latch offset replaces the whole latch. The direction register uses inverted sense: a 1 makes the pin an input and a 0 makes it drive. Pin n is bit n of every register.

Top module: `gpio_pin_bank`

## Requirements
- R1: While reset is held and in the first cycle after it, the direction register reads all ones, padOe is all zeros, padOut is all zeros and rdData is zero.
- R2: A write to offset 0x134 loads the direction register. From the next clock edge on, padOe is the bitwise inverse of the written value (bit 1 = input, pad not driven; bit 0 = output, pad driven).
- R3: A write to offset 0x13C replaces the whole output latch. padOut shows the latch from the next edge on, whatever the direction bits are.
- R4: A write to offset 0x194 sets each latch bit whose data bit is 1 and leaves every other latch bit unchanged.
- R5: A write to offset 0x190 clears each latch bit whose data bit is 1 and leaves every other latch bit unchanged.
- R6: padIn passes through two synchronizer flops and then the data-in register. A level applied before clock edge k is returned by a read of offset 0x138 that is sampled at edge k+3, and not by one sampled at edge k+2.
- R7: Reads of offsets 0x13C, 0x190 and 0x194 all return the output latch. A read of 0x134 returns the direction register.
- R8: A write to any other offset changes neither the latch nor the direction register. This includes the read-only data-in offset 0x138 and any offset whose low two bits are not zero. A read from an unmapped offset returns zero.
- R9: rdData is registered. It takes the addressed value at the edge where rdEn is sampled high and holds its value while rdEn is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe for one cycle |
| rdEn | input | 1 | Read strobe for one cycle |
| regAddr | input | 12 | Byte offset of the access |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data |
| padIn | input | 32 | Pin input levels, asynchronous |
| padOut | output | 32 | Pad output value per pin |
| padOe | output | 32 | Pad output enable per pin, 1 = drive |

## Verification
The bench walks a single one through all 32 bit positions of the set and clear aliases, against both an empty latch and a full one. A design that wrote the data instead of merging it, or that acted on zero bits, would wipe neighbouring pins. Direction values are swept with walking and mixed patterns, so an output enable that was not inverted, or that came from the wrong register, shows at the pads. Reads are taken at exactly two and three edges after an input change, which exposes a missing or extra synchronizer stage. Writes to the data-in offset, to misaligned offsets and to unused offsets must leave both registers intact, and reads from them must give zero. A decoder that matched only part of the address would fail these.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  typedef enum logic [1:0] {
    RD_ZERO  = 2'd0,
    RD_DIR   = 2'd1,
    RD_DIN   = 2'd2,
    RD_LATCH = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   dirWr;
    logic   latchWr;
    logic   setWr;
    logic   clrWr;
    logic   rdEn;
    rdSel_e rdSel;
  } bankStrobes_t;

endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int OFS_DIR   = 'h134,
  parameter int OFS_DIN   = 'h138,
  parameter int OFS_LATCH = 'h13C,
  parameter int OFS_CLR   = 'h190,
  parameter int OFS_SET   = 'h194
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] regAddr,
  output bankStrobes_t      strobes
);

  localparam logic [ADDR_W-1:0] A_DIR   = ADDR_W'(OFS_DIR);
  localparam logic [ADDR_W-1:0] A_DIN   = ADDR_W'(OFS_DIN);
  localparam logic [ADDR_W-1:0] A_LATCH = ADDR_W'(OFS_LATCH);
  localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(OFS_CLR);
  localparam logic [ADDR_W-1:0] A_SET   = ADDR_W'(OFS_SET);

  logic hitDir, hitDin, hitLatch, hitClr, hitSet;

  always_comb begin
    hitDir   = (regAddr == A_DIR);
    hitDin   = (regAddr == A_DIN);
    hitLatch = (regAddr == A_LATCH);
    hitClr   = (regAddr == A_CLR);
    hitSet   = (regAddr == A_SET);

    strobes.dirWr   = wrEn & hitDir;
    strobes.latchWr = wrEn & hitLatch;
    strobes.setWr   = wrEn & hitSet;
    strobes.clrWr   = wrEn & hitClr;
    strobes.rdEn    = rdEn;

    if (hitDir)                          strobes.rdSel = RD_DIR;
    else if (hitDin)                     strobes.rdSel = RD_DIN;
    else if (hitLatch | hitClr | hitSet) strobes.rdSel = RD_LATCH;
    else                                 strobes.rdSel = RD_ZERO;
  end

endmodule

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[s] <= '0;
        else       chain[s] <= asyncIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[s] <= '0;
        else       chain[s] <= chain[s-1];
      end
    end
  end

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/gpio_bank_dpath.sv
module gpio_bank_dpath
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  bankStrobes_t        strobes,
  input  logic [NUM_PINS-1:0] wrData,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] rdData,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe
);

  logic [NUM_PINS-1:0] dirReg;
  logic [NUM_PINS-1:0] latchReg;
  logic [NUM_PINS-1:0] dinReg;
  logic [NUM_PINS-1:0] syncedIn;
  logic [NUM_PINS-1:0] rdMux;

  gpio_bank_sync #(
    .WIDTH (NUM_PINS),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn(padIn),
    .syncOut(syncedIn)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dinReg <= '0;
    else       dinReg <= syncedIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              dirReg <= '1;
    else if (strobes.dirWr) dirReg <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                latchReg <= '0;
    else if (strobes.latchWr) latchReg <= wrData;
    else if (strobes.setWr)   latchReg <= latchReg | wrData;
    else if (strobes.clrWr)   latchReg <= latchReg & ~wrData;
  end

  always_comb begin
    unique case (strobes.rdSel)
      RD_DIR:   rdMux = dirReg;
      RD_DIN:   rdMux = dinReg;
      RD_LATCH: rdMux = latchReg;
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rdData <= '0;
    else if (strobes.rdEn) rdData <= rdMux;
  end

  assign padOut = latchReg;
  assign padOe  = ~dirReg;

endmodule

// File: rtl/gpio_pin_bank.sv
module gpio_pin_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2,
  parameter int OFS_DIR     = 'h134,
  parameter int OFS_DIN     = 'h138,
  parameter int OFS_LATCH   = 'h13C,
  parameter int OFS_CLR     = 'h190,
  parameter int OFS_SET     = 'h194
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [NUM_PINS-1:0] wrData,
  output logic [NUM_PINS-1:0] rdData,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe
);

  bankStrobes_t strobes;

  gpio_bank_ctrl #(
    .ADDR_W   (ADDR_W),
    .OFS_DIR  (OFS_DIR),
    .OFS_DIN  (OFS_DIN),
    .OFS_LATCH(OFS_LATCH),
    .OFS_CLR  (OFS_CLR),
    .OFS_SET  (OFS_SET)
  ) u_ctrl (
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .regAddr(regAddr),
    .strobes(strobes)
  );

  gpio_bank_dpath #(
    .NUM_PINS   (NUM_PINS),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .wrData (wrData),
    .padIn  (padIn),
    .rdData (rdData),
    .padOut (padOut),
    .padOe  (padOe)
  );

endmodule

// File: rtl/gpio_pin_bank_chk.sv
module gpio_pin_bank_chk #(
  parameter int NUM_PINS  = 32,
  parameter int ADDR_W    = 12,
  parameter int OFS_DIR   = 'h134,
  parameter int OFS_DIN   = 'h138,
  parameter int OFS_LATCH = 'h13C,
  parameter int OFS_CLR   = 'h190,
  parameter int OFS_SET   = 'h194
) (
  input logic                clk,
  input logic                rstN,
  input logic                wrEn,
  input logic                rdEn,
  input logic [ADDR_W-1:0]   regAddr,
  input logic [NUM_PINS-1:0] wrData,
  input logic [NUM_PINS-1:0] rdData,
  input logic [NUM_PINS-1:0] padOut,
  input logic [NUM_PINS-1:0] padOe
);

  logic atDir, atLatch, atClr, atSet, mapped;

  always_comb begin
    atDir   = (regAddr == ADDR_W'(OFS_DIR));
    atLatch = (regAddr == ADDR_W'(OFS_LATCH));
    atClr   = (regAddr == ADDR_W'(OFS_CLR));
    atSet   = (regAddr == ADDR_W'(OFS_SET));
    mapped  = atDir | atLatch | atClr | atSet | (regAddr == ADDR_W'(OFS_DIN));
  end

  AST_OE_FROM_DIR: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && atDir) |=> (padOe == ~$past(wrData))) else $error("AST_OE_FROM_DIR"); // R2

  AST_LATCH_REPLACE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && atLatch) |=> (padOut == $past(wrData))) else $error("AST_LATCH_REPLACE"); // R3

  AST_SET_MERGE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && atSet) |=> (padOut == ($past(padOut) | $past(wrData)))) else $error("AST_SET_MERGE"); // R4

  AST_CLR_MERGE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && atClr) |=> (padOut == ($past(padOut) & ~$past(wrData)))) else $error("AST_CLR_MERGE"); // R5

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && (atLatch || atSet || atClr)) |=> $stable(padOut)) else $error("AST_LATCH_HOLD"); // R8

  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && atDir) |=> $stable(padOe)) else $error("AST_DIR_HOLD"); // R8

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !mapped) |=> (rdData == '0)) else $error("AST_UNMAPPED_ZERO"); // R8

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData)) else $error("AST_RD_HOLD"); // R9

endmodule

bind gpio_pin_bank gpio_pin_bank_chk #(
  .NUM_PINS (NUM_PINS),
  .ADDR_W   (ADDR_W),
  .OFS_DIR  (OFS_DIR),
  .OFS_DIN  (OFS_DIN),
  .OFS_LATCH(OFS_LATCH),
  .OFS_CLR  (OFS_CLR),
  .OFS_SET  (OFS_SET)
) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .wrEn   (wrEn),
  .rdEn   (rdEn),
  .regAddr(regAddr),
  .wrData (wrData),
  .rdData (rdData),
  .padOut (padOut),
  .padOe  (padOe)
);

// File: tb/tb_gpio_pin_bank.sv
module tb_gpio_pin_bank;

  localparam logic [11:0] A_DIR   = 12'h134;
  localparam logic [11:0] A_DIN   = 12'h138;
  localparam logic [11:0] A_LATCH = 12'h13C;
  localparam logic [11:0] A_CLR   = 12'h190;
  localparam logic [11:0] A_SET   = 12'h194;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [31:0] padIn = '0;
  logic [31:0] padOut;
  logic [31:0] padOe;

  int checks = 0;
  int errors = 0;
  logic [31:0] mDir;
  logic [31:0] mOut;
  logic [31:0] seed = 32'h1234_5678;

  always #5 clk = ~clk;

  gpio_pin_bank dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .regAddr(regAddr),
    .wrData(wrData), .rdData(rdData), .padIn(padIn), .padOut(padOut), .padOe(padOe)
  );

  function automatic logic [31:0] nextPat(input logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; regAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rdEn = 1'b1; regAddr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic checkPads(input string req);
    chk(req, padOut, mOut);
    chk(req, padOe, ~mDir);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] r;
    logic [31:0] held;
    mDir = '1;
    mOut = '0;
    repeat (3) @(negedge clk);
    // R1: values while in reset
    chk("R1", padOe, 32'h0);
    chk("R1", padOut, 32'h0);
    chk("R1", rdData, 32'h0);
    rstN = 1'b1;
    busRead(A_DIR, r);
    chk("R1", r, 32'hFFFF_FFFF);
    chk("R1", padOe, 32'h0);

    // R2: direction sweep with walking zero and patterns
    for (int i = 0; i < 32; i++) begin
      mDir = ~(32'h1 << i);
      busWrite(A_DIR, mDir);
      checkPads("R2");
    end
    for (int i = 0; i < 8; i++) begin
      seed = nextPat(seed);
      mDir = seed;
      busWrite(A_DIR, mDir);
      checkPads("R2");
      busRead(A_DIR, r);
      chk("R7", r, mDir);
    end

    // R3: whole-latch replace, visible regardless of direction
    for (int i = 0; i < 8; i++) begin
      seed = nextPat(seed);
      mOut = seed;
      busWrite(A_LATCH, mOut);
      checkPads("R3");
    end

    // R4 and R5: walking one through set and clear on empty and full latch
    mOut = '0;
    busWrite(A_LATCH, mOut);
    for (int i = 0; i < 32; i++) begin
      mOut = mOut | (32'h1 << i);
      busWrite(A_SET, 32'h1 << i);
      chk("R4", padOut, mOut);
    end
    for (int i = 0; i < 32; i++) begin
      mOut = mOut & ~(32'h1 << i);
      busWrite(A_CLR, 32'h1 << i);
      chk("R5", padOut, mOut);
    end
    for (int i = 0; i < 6; i++) begin
      seed = nextPat(seed);
      mOut = mOut | seed;
      busWrite(A_SET, seed);
      chk("R4", padOut, mOut);
      seed = nextPat(seed);
      mOut = mOut & ~seed;
      busWrite(A_CLR, seed);
      chk("R5", padOut, mOut);
    end
    busWrite(A_SET, 32'h0);
    chk("R4", padOut, mOut);
    busWrite(A_CLR, 32'h0);
    chk("R5", padOut, mOut);

    // R7: latch readable through all three offsets
    busRead(A_LATCH, r); chk("R7", r, mOut);
    busRead(A_SET, r);   chk("R7", r, mOut);
    busRead(A_CLR, r);   chk("R7", r, mOut);

    // R6: synchronizer latency, several input patterns
    for (int i = 0; i < 6; i++) begin
      held = padIn;
      seed = nextPat(seed);
      @(negedge clk);
      padIn = seed;
      @(posedge clk);
      @(posedge clk);
      busRead(A_DIN, r);
      chk("R6", r, held);
      busRead(A_DIN, r);
      chk("R6", r, seed);
    end

    // R8: writes to read-only, misaligned and unused offsets
    busWrite(A_DIN, ~mOut);
    busWrite(12'h135, ~mDir);
    busWrite(12'h13D, ~mOut);
    busWrite(12'h196, 32'hFFFF_FFFF);
    busWrite(12'h191, 32'hFFFF_FFFF);
    busWrite(12'h000, 32'hFFFF_FFFF);
    busWrite(12'h934, 32'h0);
    checkPads("R8");
    busRead(A_DIR, r); chk("R8", r, mDir);
    busRead(12'h000, r); chk("R8", r, 32'h0);
    busRead(12'h13D, r); chk("R8", r, 32'h0);
    busRead(12'h534, r); chk("R8", r, 32'h0);

    // R9: rdData holds while rdEn low
    busRead(A_LATCH, r);
    chk("R9", r, mOut);
    busWrite(A_LATCH, ~mOut);
    mOut = ~mOut;
    @(negedge clk);
    chk("R9", rdData, ~mOut);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule